// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of a small direct-mapped write-back cache that sits on a shared snooping bus. Each line is in one of four states: Invalid, Shared (clean, possibly held elsewhere), Exclusive (clean, held only here) or Modified (dirty, held only here). Processor reads and writes arrive on a request port. Hits that need no bus traffic complete at once. Misses, upgrades and dirty evictions become bus requests, and the processor port stalls until the bus grants them.

Transactions that other caches place on the bus arrive on a snoop port. The block answers in the same cycle. It raises a shared flag when it holds the line. It raises a supply flag when it owns the line and will hand the data to the requester cache-to-cache. It raises a flush flag when the line is dirty and memory must be updated. The line's state is then downgraded at the next clock edge.

Because of the clean-exclusive state, a line that was read when no other cache held it can later be written with no bus transaction at all. Data storage, arbitration and memory are outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: snoops of any address raise no response flag, `cpu_req_ready` is high, and `cpu_resp_valid` and `bus_req_valid` are low.
- R2: A processor read that misses is accepted at a clock edge. From the next cycle, `bus_req_valid` is high with `bus_req_op`=2'b01 (read) and `bus_req_addr` equal to the request address. The request stays stable and `cpu_req_ready` stays low until a cycle with `bus_grant` high.
- R3: At the grant edge of a read fill, the line becomes Exclusive if `bus_shared_in` is low and Shared if it is high. `cpu_resp_valid` pulses in the following cycle.
- R4: A processor write to an Exclusive line issues no bus request. `cpu_resp_valid` is high in the cycle after acceptance, and the line becomes Modified.
- R5: A processor write to a Shared or Invalid line issues `bus_req_op`=2'b10 (read-exclusive) for the request address. At grant the line becomes Modified.
- R6: A processor read that hits a Shared, Exclusive or Modified line issues no bus request. `cpu_resp_valid` is high in the cycle after acceptance, and the line state is unchanged.
- R7: A snooped read (`snp_op`=2'b01) that hits a valid line raises `snp_shared`. On an Exclusive line it also raises `snp_supply`. On a Modified line it raises `snp_supply` and `snp_flush`. In every case the line ends Shared.
- R8: A snooped read-exclusive (`snp_op`=2'b10) that hits a valid line leaves `snp_shared` low. It raises `snp_supply` for Exclusive or Modified and `snp_flush` for Modified, and the line becomes Invalid.
- R9: A snoop whose tag does not match the line, that hits an Invalid line, or that carries a write-back (`snp_op`=2'b11) raises no flag and changes no state.
- R10: A miss whose direct-mapped slot holds a different Modified line first issues a write-back (`bus_req_op`=2'b11) for the old address. The fill request follows after its grant, and the old line becomes Invalid. Replacing an Exclusive or Shared line issues no write-back.
- R11: A snoop that hits the same line in the cycle a processor request is accepted is applied first. A write to an Exclusive line that is snooped by a read in that cycle therefore issues a read-exclusive request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address: tag above, index in low IDX_W bits |
| cpu_req_ready | output | 1 | Request accepted at this edge when valid |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_op | output | 2 | 01 read, 10 read-exclusive, 11 write-back |
| bus_req_addr | output | ADDR_W | Line address of the bus request |
| bus_grant | input | 1 | Pending bus request completes at this edge |
| bus_shared_in | input | 1 | Another cache holds the line (sampled with grant) |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_op | input | 2 | Snooped operation, same coding as bus_req_op |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the data cache-to-cache |
| snp_flush | output | 1 | Line is dirty; memory must take the data |

## Verification
Snoop flags are combinational, so the bench checks them 1 ns after it drives the snoop, within the same cycle. The state change is then observed through a later snoop. A hit's completion pulse appears in the cycle right after the accepting edge. A bus request appears in that same cycle, and the fill completion appears in the cycle after the grant edge. The bench drives on falling edges and samples on the next falling edge, so each result is read exactly one register stage after its cause. Requests are also re-sampled one cycle later without a grant to confirm that they are held.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_RD   = 2'b01,
        OP_RDX  = 2'b10,
        OP_WB   = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'b00,
        FSM_WB   = 2'b01,
        FSM_REQ  = 2'b10
    } ctl_fsm_e;

endpackage

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic                               snp_valid,
    input  logic [1:0]                         snp_op,
    input  logic [ADDR_W-1:0]                  snp_addr,
    input  logic [(1<<IDX_W)-1:0][1:0]         st_q,
    input  logic [(1<<IDX_W)-1:0][ADDR_W-IDX_W-1:0] tag_q,
    output logic                               upd_en,
    output logic [IDX_W-1:0]                   upd_idx,
    output logic [1:0]                         upd_state,
    output logic                               snp_shared,
    output logic                               snp_supply,
    output logic                               snp_flush
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] s_idx;
    logic [TAG_W-1:0] s_tag;
    line_state_e      cur;
    logic             hit;
    logic             owner;

    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];
    assign cur   = line_state_e'(st_q[s_idx]);
    assign hit   = snp_valid && (cur != ST_I) && (tag_q[s_idx] == s_tag);
    assign owner = (cur == ST_E) || (cur == ST_M);
    assign upd_idx = s_idx;

    always_comb begin
        upd_en     = 1'b0;
        upd_state  = ST_I;
        snp_shared = 1'b0;
        snp_supply = 1'b0;
        snp_flush  = 1'b0;
        if (hit) begin
            unique case (bus_op_e'(snp_op))
                OP_RD: begin
                    snp_shared = 1'b1;
                    snp_supply = owner;
                    snp_flush  = (cur == ST_M);
                    upd_en     = (cur != ST_S);
                    upd_state  = ST_S;
                end
                OP_RDX: begin
                    snp_supply = owner;
                    snp_flush  = (cur == ST_M);
                    upd_en     = 1'b1;
                    upd_state  = ST_I;
                end
                default: begin
                    upd_en = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               snp_upd_en,
    input  logic [IDX_W-1:0]                   snp_upd_idx,
    input  logic [1:0]                         snp_upd_state,
    input  logic                               loc_upd_en,
    input  logic [IDX_W-1:0]                   loc_idx,
    input  logic [1:0]                         loc_state,
    input  logic                               loc_tag_we,
    input  logic [ADDR_W-IDX_W-1:0]            loc_tag,
    output logic [(1<<IDX_W)-1:0][1:0]         st_q,
    output logic [(1<<IDX_W)-1:0][ADDR_W-IDX_W-1:0] tag_q
);
    localparam int TAG_W     = ADDR_W - IDX_W;
    localparam int NUM_LINES = 1 << IDX_W;

    typedef struct packed {
        logic [1:0]       st;
        logic [TAG_W-1:0] tag;
    } line_t;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        line_t ln_d, ln_q;

        // Local update was computed from the post-snoop view, so it wins.
        always_comb begin
            ln_d = ln_q;
            if (loc_upd_en && (loc_idx == IDX_W'(i))) begin
                ln_d.st = loc_state;
                if (loc_tag_we) begin
                    ln_d.tag = loc_tag;
                end
            end else if (snp_upd_en && (snp_upd_idx == IDX_W'(i))) begin
                ln_d.st = snp_upd_state;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ln_q <= '{st: ST_I, tag: '0};
            end else begin
                ln_q <= ln_d;
            end
        end

        assign st_q[i]  = ln_q.st;
        assign tag_q[i] = ln_q.tag;
    end

endmodule

// File: rtl/mesi_req_ctrl.sv
module mesi_req_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cpu_req_valid,
    input  logic                               cpu_req_write,
    input  logic [ADDR_W-1:0]                  cpu_req_addr,
    output logic                               cpu_req_ready,
    output logic                               cpu_resp_valid,
    output logic                               bus_req_valid,
    output logic [1:0]                         bus_req_op,
    output logic [ADDR_W-1:0]                  bus_req_addr,
    input  logic                               bus_grant,
    input  logic                               bus_shared_in,
    input  logic                               snp_upd_en,
    input  logic [IDX_W-1:0]                   snp_upd_idx,
    input  logic [1:0]                         snp_upd_state,
    input  logic [(1<<IDX_W)-1:0][1:0]         st_q,
    input  logic [(1<<IDX_W)-1:0][ADDR_W-IDX_W-1:0] tag_q,
    output logic                               loc_upd_en,
    output logic [IDX_W-1:0]                   loc_idx,
    output logic [1:0]                         loc_state,
    output logic                               loc_tag_we,
    output logic [ADDR_W-IDX_W-1:0]            loc_tag
);
    localparam int TAG_W     = ADDR_W - IDX_W;
    localparam int NUM_LINES = 1 << IDX_W;

    typedef struct packed {
        ctl_fsm_e          fsm;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  vtag;
        logic              resp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_LINES-1:0][1:0] post_st;
    logic [IDX_W-1:0]          r_idx;
    logic [TAG_W-1:0]          r_tag;
    line_state_e               r_cur;
    logic                      r_hit;
    logic [IDX_W-1:0]          p_idx;
    logic [TAG_W-1:0]          p_tag;
    logic                      wb_live;

    // Snoop effect applied before any local decision (same-cycle ordering).
    always_comb begin
        post_st = st_q;
        if (snp_upd_en) begin
            post_st[snp_upd_idx] = snp_upd_state;
        end
    end

    assign r_idx   = cpu_req_addr[IDX_W-1:0];
    assign r_tag   = cpu_req_addr[ADDR_W-1:IDX_W];
    assign r_cur   = line_state_e'(post_st[r_idx]);
    assign r_hit   = (r_cur != ST_I) && (tag_q[r_idx] == r_tag);
    assign p_idx   = ctl_q.addr[IDX_W-1:0];
    assign p_tag   = ctl_q.addr[ADDR_W-1:IDX_W];
    assign wb_live = (line_state_e'(st_q[p_idx]) == ST_M) && (tag_q[p_idx] == ctl_q.vtag);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.resp    = 1'b0;
        cpu_req_ready = 1'b0;
        bus_req_valid = 1'b0;
        bus_req_op    = OP_NONE;
        bus_req_addr  = '0;
        loc_upd_en    = 1'b0;
        loc_idx       = r_idx;
        loc_state     = ST_I;
        loc_tag_we    = 1'b0;
        loc_tag       = p_tag;

        unique case (ctl_q.fsm)
            FSM_IDLE: begin
                cpu_req_ready = 1'b1;
                if (cpu_req_valid) begin
                    if (r_hit && !cpu_req_write) begin
                        ctl_d.resp = 1'b1;
                    end else if (r_hit && (r_cur == ST_E || r_cur == ST_M)) begin
                        loc_upd_en = 1'b1;
                        loc_state  = ST_M;
                        ctl_d.resp = 1'b1;
                    end else begin
                        ctl_d.addr = cpu_req_addr;
                        ctl_d.wr   = cpu_req_write;
                        ctl_d.vtag = tag_q[r_idx];
                        ctl_d.fsm  = (!r_hit && r_cur == ST_M) ? FSM_WB : FSM_REQ;
                    end
                end
            end
            FSM_WB: begin
                bus_req_valid = wb_live;
                bus_req_op    = OP_WB;
                bus_req_addr  = {ctl_q.vtag, p_idx};
                if (!wb_live) begin
                    ctl_d.fsm = FSM_REQ;
                end else if (bus_grant) begin
                    loc_upd_en = 1'b1;
                    loc_idx    = p_idx;
                    loc_state  = ST_I;
                    ctl_d.fsm  = FSM_REQ;
                end
            end
            FSM_REQ: begin
                bus_req_valid = 1'b1;
                bus_req_op    = ctl_q.wr ? OP_RDX : OP_RD;
                bus_req_addr  = ctl_q.addr;
                if (bus_grant) begin
                    loc_upd_en = 1'b1;
                    loc_idx    = p_idx;
                    loc_tag_we = 1'b1;
                    loc_tag    = p_tag;
                    if (ctl_q.wr) begin
                        loc_state = ST_M;
                    end else begin
                        loc_state = bus_shared_in ? ST_S : ST_E;
                    end
                    ctl_d.resp = 1'b1;
                    ctl_d.fsm  = FSM_IDLE;
                end
            end
            default: begin
                ctl_d.fsm = FSM_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{fsm: FSM_IDLE, wr: 1'b0, addr: '0, vtag: '0, resp: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_resp_valid = ctl_q.resp;

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic              snp_flush
);
    localparam int TAG_W     = ADDR_W - IDX_W;
    localparam int NUM_LINES = 1 << IDX_W;

    logic [NUM_LINES-1:0][1:0]       st_q;
    logic [NUM_LINES-1:0][TAG_W-1:0] tag_q;
    logic                            s_upd_en;
    logic [IDX_W-1:0]                s_upd_idx;
    logic [1:0]                      s_upd_state;
    logic                            l_upd_en;
    logic [IDX_W-1:0]                l_idx;
    logic [1:0]                      l_state;
    logic                            l_tag_we;
    logic [TAG_W-1:0]                l_tag;

    mesi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) snoop_i (
        .snp_valid  (snp_valid),
        .snp_op     (snp_op),
        .snp_addr   (snp_addr),
        .st_q       (st_q),
        .tag_q      (tag_q),
        .upd_en     (s_upd_en),
        .upd_idx    (s_upd_idx),
        .upd_state  (s_upd_state),
        .snp_shared (snp_shared),
        .snp_supply (snp_supply),
        .snp_flush  (snp_flush)
    );

    mesi_req_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_resp_valid (cpu_resp_valid),
        .bus_req_valid  (bus_req_valid),
        .bus_req_op     (bus_req_op),
        .bus_req_addr   (bus_req_addr),
        .bus_grant      (bus_grant),
        .bus_shared_in  (bus_shared_in),
        .snp_upd_en     (s_upd_en),
        .snp_upd_idx    (s_upd_idx),
        .snp_upd_state  (s_upd_state),
        .st_q           (st_q),
        .tag_q          (tag_q),
        .loc_upd_en     (l_upd_en),
        .loc_idx        (l_idx),
        .loc_state      (l_state),
        .loc_tag_we     (l_tag_we),
        .loc_tag        (l_tag)
    );

    mesi_line_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) store_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .snp_upd_en    (s_upd_en),
        .snp_upd_idx   (s_upd_idx),
        .snp_upd_state (s_upd_state),
        .loc_upd_en    (l_upd_en),
        .loc_idx       (l_idx),
        .loc_state     (l_state),
        .loc_tag_we    (l_tag_we),
        .loc_tag       (l_tag),
        .st_q          (st_q),
        .tag_q         (tag_q)
    );

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_op,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_grant,
    input logic              snp_valid,
    input logic [1:0]        snp_op,
    input logic              snp_shared,
    input logic              snp_supply,
    input logic              snp_flush
);

    AST_STALL_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !cpu_req_ready); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_grant && !snp_valid) |=>
        (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_op))); // R2

    AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_grant && bus_req_op != 2'b11) |=> cpu_resp_valid); // R3

    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_grant && bus_req_op == 2'b11) |=>
        (bus_req_valid && bus_req_op != 2'b11)); // R10

    AST_FLUSH_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> snp_supply); // R7

    AST_RDX_NOT_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_op == 2'b10) |-> !snp_shared); // R8

    AST_QUIET_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!snp_valid || snp_op == 2'b11) |-> (!snp_shared && !snp_supply && !snp_flush)); // R9

    AST_READY_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |-> (cpu_req_ready && !bus_req_valid)); // R6

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_resp_valid (cpu_resp_valid),
    .bus_req_valid  (bus_req_valid),
    .bus_req_op     (bus_req_op),
    .bus_req_addr   (bus_req_addr),
    .bus_grant      (bus_grant),
    .snp_valid      (snp_valid),
    .snp_op         (snp_op),
    .snp_shared     (snp_shared),
    .snp_supply     (snp_supply),
    .snp_flush      (snp_flush)
);

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic          cpu_req_ready, cpu_resp_valid;
    logic          bus_req_valid;
    logic [1:0]    bus_req_op;
    logic [AW-1:0] bus_req_addr;
    logic          bus_grant = 1'b0, bus_shared_in = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = 2'b00;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_shared, snp_supply, snp_flush;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(3)) dut_i (.*);

    // Flag triples {shared, supply, flush} expected from a snooped read.
    localparam logic [2:0] RSP_I = 3'b000, RSP_S = 3'b100, RSP_E = 3'b110, RSP_M = 3'b111;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [2:0] exp, input string req);
        logic [2:0] got;
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        #1;
        got = {snp_shared, snp_supply, snp_flush};
        chk(got == exp, req, "snoop flags", got, exp);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // One processor access; when a bus request is expected it is granted.
    task automatic access(input logic [AW-1:0] a, input bit wr, input bit exp_bus,
                          input bit exp_wb, input logic [AW-1:0] wb_a,
                          input bit shr, input string req);
        logic [1:0] exp_op;
        exp_op = wr ? 2'b10 : 2'b01;
        @(negedge clk);
        chk(cpu_req_ready == 1'b1, req, "ready before access", cpu_req_ready, 1);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (!exp_bus) begin
            chk(cpu_resp_valid == 1'b1, req, "hit resp", cpu_resp_valid, 1);
            chk(bus_req_valid == 1'b0, req, "no bus on hit", bus_req_valid, 0);
            return;
        end
        if (exp_wb) begin
            chk(bus_req_valid && bus_req_op == 2'b11, req, "writeback op", bus_req_op, 3);
            chk(bus_req_addr == wb_a, req, "writeback addr", bus_req_addr, wb_a);
            bus_grant = 1'b1;
            @(negedge clk);
            bus_grant = 1'b0;
        end
        chk(bus_req_valid && bus_req_op == exp_op, req, "bus op", bus_req_op, exp_op);
        chk(bus_req_addr == a, req, "bus addr", bus_req_addr, a);
        chk(cpu_req_ready == 1'b0, req, "stall", cpu_req_ready, 0);
        @(negedge clk);
        chk(bus_req_valid && bus_req_addr == a && bus_req_op == exp_op, req,
            "request held", bus_req_addr, a);
        chk(cpu_resp_valid == 1'b0, req, "no early resp", cpu_resp_valid, 0);
        bus_grant = 1'b1; bus_shared_in = shr;
        @(negedge clk);
        bus_grant = 1'b0; bus_shared_in = 1'b0;
        chk(cpu_resp_valid == 1'b1, req, "fill resp", cpu_resp_valid, 1);
        chk(bus_req_valid == 1'b0, req, "bus idle after fill", bus_req_valid, 0);
    endtask

    task automatic t_reset();
        chk(cpu_req_ready == 1'b1, "R1", "ready", cpu_req_ready, 1);
        chk(cpu_resp_valid == 1'b0, "R1", "resp", cpu_resp_valid, 0);
        chk(bus_req_valid == 1'b0, "R1", "bus", bus_req_valid, 0);
        for (int i = 0; i < 8; i++) snoop(2'b01, AW'(12'h0A0 + i), RSP_I, "R1");
    endtask

    task automatic t_exclusive_path();
        access(12'h0A1, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R2");   // miss, no sharer -> E
        access(12'h0A1, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R4");   // silent E->M
        snoop(2'b01, 12'h0A1, RSP_M, "R7");                  // M -> S with flush
        access(12'h0A1, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R6");   // read hit S
        snoop(2'b01, 12'h0A1, RSP_S, "R6");                  // still S
        access(12'h0A1, 1'b1, 1'b1, 1'b0, '0, 1'b0, "R5");   // upgrade S -> M
        snoop(2'b10, 12'h0A1, 3'b011, "R8");                 // RdX on M
        snoop(2'b01, 12'h0A1, RSP_I, "R8");                  // now Invalid
    endtask

    task automatic t_shared_fill();
        access(12'h0B2, 1'b0, 1'b1, 1'b0, '0, 1'b1, "R3");
        snoop(2'b01, 12'h0B2, RSP_S, "R3");
        snoop(2'b01, 12'h0B2, RSP_S, "R7");
        access(12'h0C3, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R3");
        snoop(2'b10, 12'h0C3, 3'b010, "R8");                 // RdX on E
        snoop(2'b01, 12'h0C3, RSP_I, "R8");
        access(12'h0C3, 1'b1, 1'b1, 1'b0, '0, 1'b0, "R5");   // write miss on Invalid
        access(12'h0C3, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R6");   // read hit M
        snoop(2'b01, 12'h0C3, RSP_M, "R5");
    endtask

    task automatic t_ignored_snoops();
        access(12'h0D4, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R9");
        snoop(2'b11, 12'h0D4, RSP_I, "R9");                  // write-back op
        snoop(2'b01, 12'h1D4, RSP_I, "R9");                  // tag mismatch
        snoop(2'b10, 12'h1D4, RSP_I, "R9");
        snoop(2'b01, 12'h0D4, RSP_E, "R9");                  // still Exclusive
    endtask

    task automatic t_eviction();
        access(12'h0F5, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R10");
        access(12'h0F5, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R10");  // now M
        access(12'h1F5, 1'b0, 1'b1, 1'b1, 12'h0F5, 1'b0, "R10");
        snoop(2'b01, 12'h0F5, RSP_I, "R10");
        snoop(2'b01, 12'h1F5, RSP_E, "R10");
        access(12'h2D4, 1'b0, 1'b1, 1'b0, '0, 1'b1, "R10"); // silent replace of S
        snoop(2'b01, 12'h0D4, RSP_I, "R10");
    endtask

    task automatic t_same_cycle();
        access(12'h0E6, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R11");
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 12'h0E6;
        snp_valid = 1'b1; snp_op = 2'b01; snp_addr = 12'h0E6;
        #1;
        chk({snp_shared, snp_supply, snp_flush} == RSP_E, "R11", "snoop first",
            {snp_shared, snp_supply, snp_flush}, RSP_E);
        @(negedge clk);
        cpu_req_valid = 1'b0; snp_valid = 1'b0;
        chk(cpu_resp_valid == 1'b0, "R11", "no silent write", cpu_resp_valid, 0);
        chk(bus_req_valid && bus_req_op == 2'b10, "R11", "upgrade op", bus_req_op, 2);
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        chk(cpu_resp_valid == 1'b1, "R11", "resp", cpu_resp_valid, 1);
        snoop(2'b01, 12'h0E6, RSP_M, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exclusive_path();
        t_shared_fill();
        t_ignored_snoops();
        t_eviction();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule